// File: doc/BRIEF.md
# Presence-Detect Configuration EEPROM Two-Wire Target

This block is a two-wire serial target that models a 512-byte nonvolatile configuration memory of the kind a memory module carries for the host to read at boot. The store is four 128-byte blocks. A host reaches it with byte writes, random reads (address write, repeated START, read) and sequential reads that stream bytes while the host keeps acknowledging. The low three bits of the target's bus address come from strap inputs, so several targets can share one bus.

The lower three blocks (bytes 0 to 383) can be locked against writes, and the host can undo the lock at any time through a second bus address that reaches a one-bit control register. The top block (384 to 511) is always writable. Bytes 256 to 319 are reserved and always read as zero. After a write, the target spends an internal write time during which it ignores its addresses. A host that holds SCL low too long has its transaction aborted. SCL and SDA are resampled in the system clock, and SDA is an open-drain output with separate drive and enable. A backdoor port fills the array without bus traffic.

Top module: `spd_i2c_target`

## Requirements
- R1: After reset, and whenever the target is idle, the SDA enable `sda_oe` is low (SDA released).
- R2: The target acknowledges a 7-bit address equal to {MEM_ID, sa} (memory, default MEM_ID 4'b1010) or {CTL_ID, sa} (control, default CTL_ID 4'b0110); any other address gets NACK and the target leaves SDA released until the next START.
- R3: A memory write carries two address bytes (bit 0 of the first is address bit 8, the second is address bits 7..0) and then data bytes, each acknowledged. A random read (address write, repeated START, read address) returns the byte stored at that address.
- R4: The address pointer advances by one after each data byte written or read and wraps from 511 to 0; a sequential read continues while the host acknowledges and stops at a host NACK.
- R5: Bytes 256 to 319 read as 0x00 whatever has been stored there.
- R6: A data byte written to the control address sets the lock when its bit 0 is 1 and clears it when bit 0 is 0; a read of the control address returns 0x01 when locked and 0x00 when not. While locked, writes to bytes 0 to 383 are acknowledged but leave the stored byte unchanged.
- R7: Bytes 384 to 511 accept writes whether or not the lock is set.
- R8: After a STOP that ends a transaction in which at least one data byte was written (memory or control), the target NACKs both of its addresses for WRITE_CYCLES clock cycles, then acknowledges again.
- R9: If SCL stays low for TIMEOUT_CYCLES clock cycles during a transaction, the target releases SDA, returns to idle, and answers normally from the next START.
- R10: The target changes `sda_oe` only while the resampled SCL is low, and samples SDA on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level on the bus |
| sda_o | output | 1 | SDA drive value (always 0, open-drain) |
| sda_oe | output | 1 | SDA drive enable (1 pulls SDA low) |
| sa | input | 3 | Address straps, low three bits of both bus addresses |
| pl_we | input | 1 | Backdoor preload write strobe |
| pl_addr | input | 9 | Backdoor preload byte address |
| pl_data | input | 8 | Backdoor preload data |

## Verification
The bench builds the target with TIMEOUT_CYCLES of 100 and WRITE_CYCLES of 1000, in place of the millisecond-scale defaults. This makes the write-time NACK window reachable right after a STOP and lets an abort by SCL held low happen within a short run. The SCL period is 32 system clocks, so a single address phase fits inside the write time and the normal low phases stay well under the timeout. The straps are 3'b101, which lets a neighbouring strap value serve as the non-matching address.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACKD,
    ST_WR,
    ST_ACKW,
    ST_RD,
    ST_RACK,
    ST_WAIT
  } spd_state_e;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q    = scl_pipe[STAGES-1];
  assign sda_q    = sda_pipe[STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/spd_timer.sv
module spd_timer #(
  parameter int TIMEOUT_CYCLES = 3125000,
  parameter int WRITE_CYCLES   = 625000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic scl_q,
  input  logic wr_launch,
  output logic tmo,
  output logic busy
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  logic [TW-1:0] low_cnt;
  logic [BW-1:0] bsy_cnt;

  always_ff @(posedge clk) begin
    if (rst || scl_q || !active) low_cnt <= '0;
    else if (low_cnt != TW'(TIMEOUT_CYCLES)) low_cnt <= low_cnt + 1'b1;
  end

  assign tmo = active && !scl_q && (low_cnt == TW'(TIMEOUT_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) bsy_cnt <= '0;
    else if (wr_launch) bsy_cnt <= BW'(WRITE_CYCLES);
    else if (bsy_cnt != '0) bsy_cnt <= bsy_cnt - 1'b1;
  end

  assign busy = (bsy_cnt != '0);

  // R8: the write time only begins after a STOP that ended a write
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_launch));
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int AW         = 9,
  parameter int LOCK_LIMIT = 384,
  parameter int RSV_LO     = 256,
  parameter int RSV_HI     = 319
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          prot_we,
  input  logic          prot_d,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          prot_q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] mem_q;
  logic       rsv_q;
  logic       wr_ok;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [7:0]    mem_wd;

  // lock covers only addresses under the limit; backdoor ignores it
  assign wr_ok  = !prot_q || (wr_addr >= AW'(LOCK_LIMIT));
  assign mem_we = pl_we || (wr_en && wr_ok);
  assign mem_wa = pl_we ? pl_addr : wr_addr;
  assign mem_wd = pl_we ? pl_data : wr_data;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      rsv_q <= (rd_addr >= AW'(RSV_LO)) && (rd_addr <= AW'(RSV_HI));
      if (prot_we) prot_q <= prot_d;
    end
  end

  assign rd_data = rsv_q ? 8'h00 : mem_q;

  // R5: an address in the reserved window reads zero one cycle later
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= AW'(RSV_LO) && rd_addr <= AW'(RSV_HI)) |=> (rd_data == 8'h00));

  // R6: a control write takes effect on the next cycle
  p_prot_load_r6: assert property (@(posedge clk) disable iff (rst)
    prot_we |=> (prot_q == $past(prot_d)));
endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target
  import spd_pkg::*;
#(
  parameter int          AW             = 9,
  parameter logic [3:0]  MEM_ID         = 4'b1010,
  parameter logic [3:0]  CTL_ID         = 4'b0110,
  parameter int          TIMEOUT_CYCLES = 3125000,
  parameter int          WRITE_CYCLES   = 625000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          sda_oe,
  input  logic [2:0]    sa,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data
);
  localparam int HI = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic tmo, busy, wr_launch;

  spd_state_e    state;
  logic [3:0]    cnt;
  logic [7:0]    rx, tx;
  logic [AW-1:0] ptr;
  logic [1:0]    idx;
  logic          is_ctl, rd_mode, mack, wrote_any;
  logic          wr_en, prot_we, prot_d, prot_q;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, rd_data;
  logic          hit_mem, hit_ctl;
  logic [7:0]    rd_byte;

  spd_line_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_s), .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign wr_launch = stop_ev && wrote_any;

  spd_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .active(state != ST_IDLE), .scl_q(scl_s),
    .wr_launch(wr_launch), .tmo(tmo), .busy(busy)
  );

  spd_store #(.AW(AW)) store_i (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_we(prot_we), .prot_d(prot_d), .rd_addr(ptr), .rd_data(rd_data),
    .prot_q(prot_q)
  );

  assign hit_mem = (rx[7:1] == {MEM_ID, sa});
  assign hit_ctl = (rx[7:1] == {CTL_ID, sa});
  assign rd_byte = is_ctl ? {7'b0, prot_q} : rd_data;
  assign sda_o   = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      idx       <= '0;
      is_ctl    <= 1'b0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      wrote_any <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      prot_we   <= 1'b0;
      prot_d    <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      prot_we <= 1'b0;
      if (tmo) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        wrote_any <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_DEV;
        cnt    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        wrote_any <= 1'b0;
      end else begin
        if (scl_rise) begin
          cnt <= cnt + 1'b1;
          if (state == ST_DEV || state == ST_WR) rx <= {rx[6:0], sda_s};
          if (state == ST_RACK) mack <= !sda_s;
        end
        if (scl_fall) begin
          unique case (state)
            ST_DEV: if (cnt == 4'd8) begin
              cnt <= '0;
              if ((hit_mem || hit_ctl) && !busy) begin
                sda_oe  <= 1'b1;
                is_ctl  <= hit_ctl;
                rd_mode <= rx[0];
                state   <= ST_ACKD;
              end else begin
                state <= ST_WAIT;
              end
            end
            ST_ACKD: begin
              cnt <= '0;
              if (rd_mode) begin
                tx     <= rd_byte;
                sda_oe <= !rd_byte[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
            ST_WR: if (cnt == 4'd8) begin
              cnt    <= '0;
              sda_oe <= 1'b1;
              state  <= ST_ACKW;
              if (is_ctl) begin
                prot_we   <= 1'b1;
                prot_d    <= rx[0];
                wrote_any <= 1'b1;
              end else if (idx == 2'd0) begin
                ptr[AW-1:8] <= rx[HI-1:0];
                idx         <= 2'd1;
              end else if (idx == 2'd1) begin
                ptr[7:0] <= rx;
                idx      <= 2'd2;
              end else begin
                wr_en     <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= rx;
                ptr       <= ptr + 1'b1;
                wrote_any <= 1'b1;
              end
            end
            ST_ACKW: begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
            ST_RD: if (cnt == 4'd8) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              state  <= ST_RACK;
              if (!is_ctl) ptr <= ptr + 1'b1;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= !tx[6];
            end
            ST_RACK: begin
              cnt <= '0;
              if (mack) begin
                tx     <= rd_byte;
                sda_oe <= !rd_byte[7];
                state  <= ST_RD;
              end else begin
                state <= ST_WAIT;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R1: idle target never pulls SDA
  p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R10: SDA drive moves only while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R9: expiry of the low-clock limit releases the bus
  p_tmo_release_r9: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (!sda_oe && state == ST_IDLE));

  // R8: no address acknowledge during the write time
  p_ack_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACKD) |-> !busy);
endmodule

// File: tb/spd_i2c_target_tb_top.sv
`timescale 1ns/1ps
module spd_i2c_target_tb_top;
  localparam int TMO = 100;
  localparam int WRC = 1000;
  localparam int Q   = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MEM_A = {4'b1010, STRAP};
  localparam logic [6:0] CTL_A = {4'b0110, STRAP};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_o, sda_oe;
  logic pl_we = 1'b0;
  logic [8:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  wire sda_line = m_sda & ~(sda_oe & ~sda_o);

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [512];
  bit ref_prot = 1'b0;

  always #4 clk = ~clk;

  spd_i2c_target #(.TIMEOUT_CYCLES(TMO), .WRITE_CYCLES(WRC)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .sa(STRAP),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  task automatic wait_cyc(input int n);
    #(8 * n);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    if (a >= 256 && a <= 319) return 8'h00;
    return ref_mem[a];
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(2*Q);
    m_sda = 1'b0; wait_cyc(2*Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(2*Q);
    m_sda = 1'b1; wait_cyc(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_cyc(Q);
      m_scl = 1'b1; wait_cyc(2*Q);
      m_scl = 1'b0; wait_cyc(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b);
    m_sda = 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    ack = sda_line; wait_cyc(Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic recv_byte(input bit more, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_cyc(Q);
      m_scl = 1'b1; wait_cyc(Q);
      b[i] = sda_line; wait_cyc(Q);
      m_scl = 1'b0; wait_cyc(Q);
    end
    m_sda = more ? 1'b0 : 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(2*Q);
    m_scl = 1'b0; wait_cyc(Q);
    m_sda = 1'b1;
  endtask

  task automatic mem_write(input int a, input logic [7:0] d, output logic ack_d);
    logic ack;
    bus_start();
    send_byte({MEM_A, 1'b0}, ack);
    send_byte({7'b0, a[8]}, ack);
    send_byte(a[7:0], ack);
    send_byte(d, ack_d);
    bus_stop();
    if (!ref_prot || a >= 384) ref_mem[a] = d;
    wait_cyc(WRC + 100);
  endtask

  task automatic ctl_write(input bit lock);
    logic ack;
    bus_start();
    send_byte({CTL_A, 1'b0}, ack);
    send_byte({7'b0, lock}, ack);
    bus_stop();
    ref_prot = lock;
    wait_cyc(WRC + 100);
  endtask

  task automatic mem_read(input int a, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({MEM_A, 1'b0}, ack);
    send_byte({7'b0, a[8]}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte({MEM_A, 1'b1}, ack);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == exp_byte(a), tag, b, exp_byte(a));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait_cyc(150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int a;
    logic [7:0] d;
    void'($urandom(32'd2024));
    wait_cyc(10);
    rst = 1'b0;
    wait_cyc(5);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    for (int i = 0; i < 512; i++) begin
      pl_addr = 9'(i); pl_data = 8'($urandom); pl_we = 1'b1;
      ref_mem[i] = pl_data;
      wait_cyc(1);
    end
    pl_we = 1'b0;
    wait_cyc(4);

    // R3 random reads at random addresses
    for (int i = 0; i < 6; i++) mem_read(int'($urandom % 512), "R3 random read");
    // R5 reserved window edges and neighbours
    mem_read(256, "R5 reserved low edge");
    mem_read(319, "R5 reserved high edge");
    mem_read(255, "R5 below reserved");
    mem_read(320, "R5 above reserved");

    // R2 address matching
    bus_start();
    send_byte({MEM_A, 1'b1}, ack);
    check(ack == 1'b0, "R2 memory address ack", ack, 0);
    recv_byte(1'b0, b);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack);
    check(ack == 1'b1, "R2 wrong strap nack", ack, 1);
    send_byte(8'h00, ack);
    check(ack == 1'b1, "R2 ignored until start", ack, 1);
    bus_stop();
    bus_start();
    send_byte({4'b0011, STRAP, 1'b0}, ack);
    check(ack == 1'b1, "R2 foreign id nack", ack, 1);
    bus_stop();

    // R3 write then read back
    mem_write(77, 8'h5A, ack);
    check(ack == 1'b0, "R3 data byte ack", ack, 0);
    mem_read(77, "R3 write readback");

    // R8 write time nack
    bus_start();
    send_byte({MEM_A, 1'b0}, ack);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    ref_mem[16] = 8'hC3;
    bus_start();
    send_byte({MEM_A, 1'b1}, ack);
    check(ack == 1'b1, "R8 busy nack", ack, 1);
    bus_stop();
    wait_cyc(WRC + 100);
    bus_start();
    send_byte({MEM_A, 1'b1}, ack);
    check(ack == 1'b0, "R8 ack after write time", ack, 0);
    recv_byte(1'b0, b);
    bus_stop();
    mem_read(16, "R8 write landed");

    // R4 sequential read across wrap
    bus_start();
    send_byte({MEM_A, 1'b0}, ack);
    send_byte(8'h01, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte({MEM_A, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      check(b == exp_byte((510 + i) % 512), "R4 sequential wrap", b, exp_byte((510 + i) % 512));
    end
    bus_stop();

    // R6 lock set
    ctl_write(1'b1);
    bus_start();
    send_byte({CTL_A, 1'b1}, ack);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h01, "R6 control reads locked", b, 1);
    mem_write(100, ~ref_mem[100], ack);
    check(ack == 1'b0, "R6 locked write acked", ack, 0);
    mem_read(100, "R6 locked byte unchanged");
    mem_write(383, ~ref_mem[383], ack);
    mem_read(383, "R6 lock top edge");
    // R7 upper block writable while locked
    mem_write(384, ~ref_mem[384], ack);
    mem_read(384, "R7 upper edge writable");
    mem_write(511, 8'h3C, ack);
    mem_read(511, "R7 last byte writable");
    // R6 lock cleared
    ctl_write(1'b0);
    bus_start();
    send_byte({CTL_A, 1'b1}, ack);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h00, "R6 control reads unlocked", b, 0);
    mem_write(100, 8'hA5, ack);
    mem_read(100, "R6 unlocked write lands");

    // R9 clock-low timeout during an address acknowledge
    bus_start();
    send_bits({MEM_A, 1'b0});
    wait_cyc(4);
    check(sda_oe == 1'b1, "R9 ack driven before timeout", sda_oe, 1);
    wait_cyc(TMO + 40);
    check(sda_oe == 1'b0, "R9 released after timeout", sda_oe, 0);
    bus_stop();
    mem_read(100, "R9 normal after timeout");

    // mixed random writes with random locking (R6 R7 R3)
    for (int i = 0; i < 10; i++) begin
      if (($urandom % 4) == 0) ctl_write(1'($urandom));
      a = int'($urandom % 512);
      d = 8'($urandom);
      mem_write(a, d, ack);
      check(ack == 1'b0, "R6 random write ack", ack, 0);
      mem_read(a, "R7 random lock readback");
    end

    finish_run();
  end
endmodule